// File: doc/BRIEF.md
# Page Latch Write Commit Unit

This block sits between a serial-bus slave and a byte-wide storage array. While a write transaction is in progress, the slave hands over each received data byte together with its 5-bit position inside a 32-byte page. The block keeps these bytes in a page latch. When the slave reports that the bus transaction has ended, the block writes the whole page back to the array. That write is a timed cycle, and for its whole length the block reports busy so that the slave can refuse to acknowledge.

The first byte of a transaction loads the latch with the current contents of the addressed page. Later bytes then overwrite only the positions they address. As a result, a partial-page write rewrites unloaded positions with the same values they already held.

The protect input is looked at in only one cycle, the one in which the end of the transaction is reported. If protect is high in that cycle, the latch is discarded. In that case there are no array writes and busy never rises.

Top module: `pgbuf_commit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy`, `done` and `arr_wr_en` are all low.
- R2: Each accepted load places `ld_data` at position `ld_off` of the latch. The page index is `page_base[ADDR_W-1:5]`, taken at the first load of the transaction. The low five bits of `page_base` are ignored.
- R3: When a later load in the same transaction uses a position that was already loaded, the later data replaces the earlier data. This covers offsets that wrap past 31 back to 0.
- R4: A commit starts only when `stop_seen` is high in a cycle in which at least one load has been accepted since the last stop. A stop with no loads before it has no effect: there are no writes and `busy` stays low.
- R5: On the first load of a transaction, every position of the latch that the load does not address is filled from `page_img`. Bits `8*i+7:8*i` of `page_img` hold the byte at offset i of the page selected by `page_rd_idx`.
- R6: `wp` is sampled only in the stop cycle. If it is high there, the latch is dropped: there are no array writes and `busy` stays low. A change of `wp` after the stop does not alter a commit already started.
- R7: A commit writes all 32 bytes, one per cycle, at offsets 0, 1, …, 31 in that order. The first write is in the cycle after the stop. Each write address is `{page index, offset}`.
- R8: `busy` rises in the cycle after an accepted stop and stays high for exactly `TWC_CYCLES` cycles.
- R9: `done` is high for exactly one cycle, the first cycle in which `busy` is low again after a commit. At no other time is `done` high.
- R10: While `busy` is high, `ld_valid` and `stop_seen` are ignored. Such loads do not reach the latch, and they do not begin a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_base | input | ADDR_W | Transaction address; only the page bits are used |
| ld_valid | input | 1 | One data byte is being loaded |
| ld_off | input | 5 | Position of the byte within the page |
| ld_data | input | DATA_W | Byte value |
| stop_seen | input | 1 | One-cycle pulse when the bus transaction ends |
| wp | input | 1 | Write protect, sampled at stop |
| page_img | input | PAGE_BYTES*DATA_W | Current array contents of page `page_rd_idx` |
| page_rd_idx | output | ADDR_W-5 | Page being offered for preload |
| arr_wr_en | output | 1 | Array byte write strobe |
| arr_wr_addr | output | ADDR_W | Array byte write address |
| arr_wr_data | output | DATA_W | Array byte write data |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle pulse when a write cycle ends |

## Verification
The bench builds the block with `ADDR_W` = 8, giving eight pages, and with `TWC_CYCLES` = 40. At that size the bench can keep a full shadow copy of the array. Every commit can then be compared byte for byte against that copy, and a partial-page write can show that a dropped or ignored transaction left old contents in place. The short write cycle leaves eight idle cycles after the 32 strobes. It also lets the bench count the busy window exactly and try loads, stops and protect changes in the middle of it.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [0:0] {
    PGC_IDLE = 1'b0,
    PGC_PROG = 1'b1
  } pgc_state_e;
endpackage

// File: rtl/pgc_latch.sv
module pgc_latch #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                           clk,
  input  logic                           ld_en,
  input  logic                           preload,
  input  logic [OFF_W-1:0]               ld_off,
  input  logic [DATA_W-1:0]              ld_data,
  input  logic [PAGE_BYTES*DATA_W-1:0]   page_img,
  input  logic [OFF_W-1:0]               rd_off,
  output logic [DATA_W-1:0]              rd_data
);
  logic [DATA_W-1:0] cell_q [PAGE_BYTES];

  // One register per byte position; the addressed byte takes the load,
  // the others take the array image only on the first load.
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
    logic hit;
    logic cell_en;
    logic [DATA_W-1:0] cell_d;
    assign hit     = (ld_off == OFF_W'(g));
    assign cell_en = ld_en && (hit || preload);
    assign cell_d  = hit ? ld_data : page_img[g*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (cell_en) begin
        cell_q[g] <= cell_d;
      end
    end
  end

  assign rd_data = cell_q[rd_off];
endmodule

// File: rtl/pgc_seq.sv
module pgc_seq
  import pgc_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int TWC_CYCLES = 200,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(TWC_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             stop_seen,
  input  logic             wp,
  output logic             ld_en,
  output logic             preload,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_off
);
  pgc_state_e       state_q, state_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    ld_en   = (state_q == PGC_IDLE) && ld_valid;
    preload = ld_en && !armed_q;
    case (state_q)
      PGC_IDLE: begin
        if (ld_en) begin
          armed_d = 1'b1;
        end
        if (stop_seen) begin
          armed_d = 1'b0;
          if (armed_q && !wp) begin
            state_d = PGC_PROG;
            cnt_d   = '0;
          end
        end
      end
      PGC_PROG: begin
        if (cnt_q == CNT_W'(TWC_CYCLES - 1)) begin
          state_d = PGC_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PGC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PGC_IDLE;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q == PGC_PROG);
  assign done   = done_q;
  assign wr_en  = busy && (cnt_q < CNT_W'(PAGE_BYTES));
  assign wr_off = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int TWC_CYCLES = 200,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            page_base,
  input  logic                         ld_valid,
  input  logic [OFF_W-1:0]             ld_off,
  input  logic [DATA_W-1:0]            ld_data,
  input  logic                         stop_seen,
  input  logic                         wp,
  input  logic [PAGE_BYTES*DATA_W-1:0] page_img,
  output logic [PG_W-1:0]              page_rd_idx,
  output logic                         arr_wr_en,
  output logic [ADDR_W-1:0]            arr_wr_addr,
  output logic [DATA_W-1:0]            arr_wr_data,
  output logic                         busy,
  output logic                         done
);
  logic             ld_en;
  logic             preload;
  logic [OFF_W-1:0] wr_off;
  logic [PG_W-1:0]  pg_q;

  pgc_seq #(
    .PAGE_BYTES(PAGE_BYTES),
    .TWC_CYCLES(TWC_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .stop_seen(stop_seen),
    .wp       (wp),
    .ld_en    (ld_en),
    .preload  (preload),
    .busy     (busy),
    .done     (done),
    .wr_en    (arr_wr_en),
    .wr_off   (wr_off)
  );

  pgc_latch #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W)
  ) u_latch (
    .clk     (clk),
    .ld_en   (ld_en),
    .preload (preload),
    .ld_off  (ld_off),
    .ld_data (ld_data),
    .page_img(page_img),
    .rd_off  (wr_off),
    .rd_data (arr_wr_data)
  );

  // Page index is frozen at the first load of each transaction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= '0;
    end else if (preload) begin
      pg_q <= page_base[ADDR_W-1:OFF_W];
    end
  end

  assign page_rd_idx = page_base[ADDR_W-1:OFF_W];
  assign arr_wr_addr = {pg_q, wr_off};
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int ADDR_W     = 13,
  parameter int TWC_CYCLES = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              stop_seen,
  input logic              wp,
  input logic              arr_wr_en,
  input logic [ADDR_W-1:0] arr_wr_addr
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len_q <= '0;
    end else if (busy) begin
      busy_len_q <= busy_len_q + 1;
    end else begin
      busy_len_q <= '0;
    end
  end

  assert_wr_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> busy);

  assert_wr_addr_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && $past(arr_wr_en)) |-> (arr_wr_addr == $past(arr_wr_addr) + 1'b1));

  assert_busy_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_seen));

  assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len_q == TWC_CYCLES));

  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_protect_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && wp && !busy) |=> !busy);
endmodule

bind pgbuf_commit pgc_checker #(
  .ADDR_W    (ADDR_W),
  .TWC_CYCLES(TWC_CYCLES)
) u_pgc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .stop_seen  (stop_seen),
  .wp         (wp),
  .arr_wr_en  (arr_wr_en),
  .arr_wr_addr(arr_wr_addr)
);

// File: tb/pgbuf_commit_bench.sv
module pgbuf_commit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PB   = 32;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int TWC  = 40;
  localparam int OW   = 5;
  localparam int PGW  = AW - OW;
  localparam int NMEM = 1 << AW;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] page_base;
  logic ld_valid;
  logic [OW-1:0] ld_off;
  logic [DW-1:0] ld_data;
  logic stop_seen;
  logic wp;
  logic [PB*DW-1:0] page_img;
  logic [PGW-1:0] page_rd_idx;
  logic arr_wr_en;
  logic [AW-1:0] arr_wr_addr;
  logic [DW-1:0] arr_wr_data;
  logic busy;
  logic done;

  logic [DW-1:0] arr [NMEM];
  logic [DW-1:0] ref_mem [NMEM];
  wr_item_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgbuf_commit #(
    .PAGE_BYTES(PB), .ADDR_W(AW), .DATA_W(DW), .TWC_CYCLES(TWC)
  ) u_pgbuf_commit (
    .clk(clk), .rst_n(rst_n), .page_base(page_base), .ld_valid(ld_valid),
    .ld_off(ld_off), .ld_data(ld_data), .stop_seen(stop_seen), .wp(wp),
    .page_img(page_img), .page_rd_idx(page_rd_idx), .arr_wr_en(arr_wr_en),
    .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data), .busy(busy), .done(done)
  );

  // Array model: written by the block, read back as a whole page.
  always @(posedge clk) begin
    if (arr_wr_en) arr[arr_wr_addr] <= arr_wr_data;
  end
  always_comb begin
    for (int i = 0; i < PB; i++) page_img[i*DW +: DW] = arr[{page_rd_idx, OW'(i)}];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pop one expected write per strobe (R7 order, R2/R5 content).
  always @(negedge clk) begin
    if (rst_n && arr_wr_en) begin
      if (exp_q.size() == 0) begin
        check(0, "R6", "unexpected array write addr", int'(arr_wr_addr), -1);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(arr_wr_addr == it.addr, "R7", "write address", int'(arr_wr_addr), int'(it.addr));
        check(arr_wr_data == it.data, "R5", "write data", int'(arr_wr_data), int'(it.data));
      end
    end
  end

  // Driver: load n bytes starting at start_off (wrapping), then stop.
  task automatic do_write(input int pg, input int start_off, input int n,
                          input int seed, input bit wp_at_stop);
    logic [DW-1:0] img [PB];
    for (int i = 0; i < PB; i++) img[i] = ref_mem[{PGW'(pg), OW'(i)}];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      page_base = {PGW'(pg), OW'(17 + i)};   // low bits must not matter (R2)
      ld_valid  = 1'b1;
      ld_off    = OW'(start_off + i);        // wraps within the page (R3)
      ld_data   = DW'(seed + i * 7);
      img[(start_off + i) % PB] = DW'(seed + i * 7);
    end
    @(negedge clk);
    ld_valid  = 1'b0;
    stop_seen = 1'b1;
    wp        = wp_at_stop;
    if (!wp_at_stop && n > 0) begin
      for (int i = 0; i < PB; i++) begin
        wr_item_t it;
        it.addr = {PGW'(pg), OW'(i)};
        it.data = img[i];
        exp_q.push_back(it);
        ref_mem[it.addr] = img[i];
      end
    end
    @(negedge clk);
    stop_seen = 1'b0;
  endtask

  // Count busy cycles, optionally poking inputs inside the window.
  task automatic wait_commit(input bit poke);
    int n = 0;
    while (busy && n < TWC + 10) begin
      if (poke && n == 2) begin
        ld_valid = 1'b1; ld_off = 5'd3; ld_data = 8'hEE; stop_seen = 1'b1;
        page_base = {PGW'(5), OW'(0)};
      end else if (poke && n == 3) begin
        ld_valid = 1'b0; stop_seen = 1'b0;
      end
      if (n == 5) wp = 1'b1;                 // protect raised after stop (R6)
      n++;
      @(negedge clk);
    end
    wp = 1'b0;
    check(n == TWC, "R8", "busy length", n, TWC);
    check(done == 1'b1, "R9", "done at busy fall", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", int'(done), 0);
  endtask

  task automatic expect_idle(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      check(busy == 1'b0, req, "busy stays low", int'(busy), 0);
      check(done == 1'b0, req, "done stays low", int'(done), 0);
      @(negedge clk);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    for (int i = 0; i < NMEM; i++) begin
      arr[i]     = DW'(i * 3 + 1);
      ref_mem[i] = DW'(i * 3 + 1);
    end
    rst_n = 1'b0; page_base = '0; ld_valid = 1'b0; ld_off = '0; ld_data = '0;
    stop_seen = 1'b0; wp = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && arr_wr_en == 0, "R1", "outputs in reset",
          int'({busy, done, arr_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && arr_wr_en == 0, "R1", "outputs after reset",
          int'({busy, done, arr_wr_en}), 0);

    // Full page starting mid-page, wrapping through offset 0 (R2, R3, R7)
    do_write(2, 5, 32, 8'h40, 1'b0);
    check(busy == 1'b1, "R8", "busy after stop", int'(busy), 1);
    wait_commit(1'b0);

    // Partial write: rest of page refreshed from array (R5)
    do_write(2, 9, 3, 8'h90, 1'b0);
    wait_commit(1'b0);

    // More than a page: later bytes overwrite earlier ones (R3)
    do_write(6, 30, 40, 8'h11, 1'b0);
    wait_commit(1'b0);

    // Protected at stop: dropped, no busy (R6)
    do_write(3, 0, 4, 8'hA0, 1'b1);
    expect_idle("R6", 4);
    // Page 3 must still hold old contents: a one-byte write shows them (R6)
    do_write(3, 20, 1, 8'h55, 1'b0);
    wait_commit(1'b0);

    // Stop with no loads has no effect (R4)
    @(negedge clk); stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
    expect_idle("R4", 4);

    // Loads and stops during busy are ignored (R10); wp raised inside window
    do_write(4, 0, 2, 8'h22, 1'b0);
    wait_commit(1'b1);
    expect_idle("R10", 3);
    // Page 5 offset 3 untouched: a single load elsewhere exposes it (R10)
    do_write(5, 10, 1, 8'h77, 1'b0);
    wait_commit(1'b0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7", "all expected writes seen", exp_q.size(), 0);
    report();
  end
endmodule